// File: doc/BRIEF.md
# Destination Register Update Combiner

This block stands between an execution result and the register-file write port. It merges a freshly computed word with the current contents of the destination register. A mode field chooses how they are merged: plain replacement, XOR, inversion of the result, add, AND, OR, subtract, or a category-dependent fourth arithmetic or logic form. One shared adder carries out every arithmetic merge, and the XOR and inversion forms run on that same adder with its carries suppressed.

Loads can write a 64-bit register pair one word at a time, the low word first and the high word on a later cycle. A fourth mode bit, defined only for loads, links the two halves. The carry or borrow out of the low-word merge is held in a one-bit register and fed into the high-word merge. A conditional move whose condition failed leaves the destination untouched and drops the write enable.

Top module: `dru_combiner`

## Requirements
- R1: With `mode_i` = 4'b0000, `merged_o` equals `result_i`, `carry_o` is 0 and `we_o` is 1.
- R2: With mode low bits 3'b001, `merged_o` = `result_i ^ old_i` and `carry_o` is 0.
- R3: With mode low bits 3'b010, `merged_o` = `~result_i` whatever `old_i` holds, and `carry_o` is 0.
- R4: With mode low bits 3'b011 and no link, `merged_o` = `old_i + result_i` with no carry in, and `carry_o` is the carry out of bit W-1.
- R5: Mode low bits 3'b100 give `result_i & old_i`. Mode low bits 3'b101 give `result_i | old_i`. In both cases `carry_o` is 0.
- R6: With mode low bits 3'b111 and no link, `merged_o` = `old_i - result_i`. `carry_o` is the no-borrow flag, which is 1 when `old_i >= result_i` unsigned.
- R7: With mode low bits 3'b110 and category arithmetic (`cat_i` = 2'd0), load (2'd2) or reserved (2'd3), `merged_o` = `result_i - old_i`, and `carry_o` is the no-borrow flag.
- R8: With mode low bits 3'b110 and category bitwise (`cat_i` = 2'd1), `merged_o` = `~result_i & old_i` and `carry_o` is 0.
- R9: For categories other than load, `mode_i[3]` is ignored.
- R10: For a load pair (`cat_i` = 2'd2, `pair_i` = 1), the linked codes 4'b1011 (add) and 4'b1111 (old minus result) chain the two words. On the low word (`hi_sel_i` = 0), the block captures `carry_o` at the clock edge. On a later high word (`hi_sel_i` = 1) with the same code, the merge uses the captured bit as its carry in.
- R11: A load whose `mode_i[3]` is 1 with low bits other than 3'b011 or 3'b111 performs a direct write (`merged_o` = `result_i`, `carry_o` = 0).
- R12: When `cmov_i` = 1 and `cond_pass_i` = 0, `we_o` is 0, `merged_o` equals `old_i` and `carry_o` is 0. With `cond_pass_i` = 1, the normal merge is written with `we_o` = 1.
- R13: Synchronous reset clears the captured link carry, so a linked high-word add issued right after reset adds no carry.
- R14: The high word of an unlinked load pair (code 4'b0011 with `hi_sel_i` = 1) is a plain add that ignores any carry captured earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the link-carry register |
| rst | input | 1 | Synchronous active-high reset |
| result_i | input | W | New result word from the execution unit or load path |
| old_i | input | W | Current destination register contents |
| mode_i | input | 4 | Update mode; bit 3 is meaningful for loads only |
| cat_i | input | 2 | Category: 0 arithmetic, 1 bitwise, 2 load, 3 reserved (treated as arithmetic) |
| pair_i | input | 1 | Operation writes one word of a 64-bit register pair |
| hi_sel_i | input | 1 | Selects the high word of the pair (0 = low word) |
| cmov_i | input | 1 | Operation is a conditional move |
| cond_pass_i | input | 1 | Condition of the conditional move evaluated true |
| merged_o | output | W | Word to write into the destination |
| we_o | output | 1 | Write enable for the destination |
| carry_o | output | 1 | Carry or no-borrow out of the arithmetic merge |

## Verification
On every cycle, the checker confirms the held destination and dropped write enable of a failed conditional move, direct writes, XOR, inversion and AND merges, and the fallback of undefined load codes. It also relates a linked high-word add to the carry the block gave out one cycle earlier. The numeric results of add, subtract and reverse subtract depend on operand values, so the bench's scenarios are what show them. These scenarios cover the wrapping and borrow corners, the category split of mode 110, and the fact that bit 3 is ignored outside loads. They also show that a captured carry is cleared by reset and left out of unlinked pairs.

// File: rtl/dru_pkg.sv
package dru_pkg;

    typedef enum logic [1:0] {
        CAT_ARITH   = 2'd0,
        CAT_BITWISE = 2'd1,
        CAT_LOAD    = 2'd2,
        CAT_RSVD    = 2'd3
    } dru_cat_e;

    typedef enum logic [2:0] {
        OP_PASS  = 3'd0,
        OP_ADDER = 3'd1,
        OP_AND   = 3'd2,
        OP_OR    = 3'd3,
        OP_ANDN  = 3'd4
    } dru_op_e;

    typedef enum logic [1:0] {
        A_OLD  = 2'd0,
        A_NEW  = 2'd1,
        A_ONES = 2'd2
    } dru_asrc_e;

    typedef enum logic [1:0] {
        B_NEW     = 2'd0,
        B_NOT_NEW = 2'd1,
        B_NOT_OLD = 2'd2
    } dru_bsrc_e;

    typedef struct packed {
        dru_op_e   op;
        dru_asrc_e a_src;
        dru_bsrc_e b_src;
        logic      cin;
        logic      no_carry;
        logic      linked;
    } dru_ctl_t;

    localparam int MODE_W = 4;

    localparam logic [2:0] M_WRITE = 3'b000;
    localparam logic [2:0] M_XOR   = 3'b001;
    localparam logic [2:0] M_INV   = 3'b010;
    localparam logic [2:0] M_ADD   = 3'b011;
    localparam logic [2:0] M_AND   = 3'b100;
    localparam logic [2:0] M_OR    = 3'b101;
    localparam logic [2:0] M_CAT   = 3'b110;
    localparam logic [2:0] M_SUB   = 3'b111;

    function automatic dru_ctl_t dru_decode(input logic [MODE_W-1:0] mode,
                                            input dru_cat_e cat);
        dru_ctl_t c;
        logic     ext;
        c = '{op: OP_PASS, a_src: A_OLD, b_src: B_NEW,
              cin: 1'b0, no_carry: 1'b1, linked: 1'b0};
        ext = (cat == CAT_LOAD) && mode[3];
        if (ext && (mode[2:0] != M_ADD) && (mode[2:0] != M_SUB)) begin
            c.op = OP_PASS;
        end else begin
            unique case (mode[2:0])
                M_WRITE: c.op = OP_PASS;
                M_XOR: begin
                    c.op = OP_ADDER;
                end
                M_INV: begin
                    c.op    = OP_ADDER;
                    c.a_src = A_ONES;
                end
                M_ADD: begin
                    c.op       = OP_ADDER;
                    c.no_carry = 1'b0;
                    c.linked   = ext;
                end
                M_AND: c.op = OP_AND;
                M_OR:  c.op = OP_OR;
                M_CAT: begin
                    if (cat == CAT_BITWISE) begin
                        c.op = OP_ANDN;
                    end else begin
                        c.op       = OP_ADDER;
                        c.a_src    = A_NEW;
                        c.b_src    = B_NOT_OLD;
                        c.cin      = 1'b1;
                        c.no_carry = 1'b0;
                    end
                end
                M_SUB: begin
                    c.op       = OP_ADDER;
                    c.b_src    = B_NOT_NEW;
                    c.cin      = 1'b1;
                    c.no_carry = 1'b0;
                    c.linked   = ext;
                end
                default: c.op = OP_PASS;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/dru_mode_decode.sv
module dru_mode_decode
    import dru_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    input  dru_cat_e          cat_i,
    output dru_ctl_t          ctl_o
);
    always_comb begin
        ctl_o = dru_decode(mode_i, cat_i);
    end
endmodule

// File: rtl/dru_adder.sv
module dru_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         no_carry_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    localparam int XW = W + 1;

    logic [XW-1:0] full;

    always_comb begin
        full = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        if (no_carry_i) begin
            sum_o  = a_i ^ b_i;
            cout_o = 1'b0;
        end else begin
            sum_o  = full[W-1:0];
            cout_o = full[XW-1];
        end
    end
endmodule

// File: rtl/dru_bitlogic.sv
module dru_bitlogic
    import dru_pkg::*;
#(
    parameter int W = 32
) (
    input  dru_op_e      op_i,
    input  logic [W-1:0] new_i,
    input  logic [W-1:0] old_i,
    output logic [W-1:0] y_o
);
    always_comb begin
        unique case (op_i)
            OP_AND:  y_o = new_i & old_i;
            OP_OR:   y_o = new_i | old_i;
            OP_ANDN: y_o = ~new_i & old_i;
            default: y_o = new_i;
        endcase
    end
endmodule

// File: rtl/dru_carry_link.sv
module dru_carry_link (
    input  logic clk,
    input  logic rst,
    input  logic capture_i,
    input  logic carry_i,
    output logic carry_q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q_o <= 1'b0;
        end else if (capture_i) begin
            carry_q_o <= carry_i;
        end
    end
endmodule

// File: rtl/dru_combiner.sv
module dru_combiner
    import dru_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] result_i,
    input  logic [W-1:0] old_i,
    input  logic [3:0]   mode_i,
    input  logic [1:0]   cat_i,
    input  logic         pair_i,
    input  logic         hi_sel_i,
    input  logic         cmov_i,
    input  logic         cond_pass_i,
    output logic [W-1:0] merged_o,
    output logic         we_o,
    output logic         carry_o
);
    dru_cat_e     cat;
    dru_ctl_t     ctl;
    logic         link_lo;
    logic         link_hi;
    logic         carry_q;
    logic         add_cin;
    logic [W-1:0] op_a;
    logic [W-1:0] op_b;
    logic [W-1:0] add_sum;
    logic         add_cout;
    logic [W-1:0] logic_y;
    logic [W-1:0] merge_val;
    logic         upd_ok;

    assign cat = dru_cat_e'(cat_i);

    dru_mode_decode u_dec (
        .mode_i (mode_i),
        .cat_i  (cat),
        .ctl_o  (ctl)
    );

    assign upd_ok  = !(cmov_i && !cond_pass_i);
    assign link_lo = ctl.linked && pair_i && !hi_sel_i;
    assign link_hi = ctl.linked && pair_i && hi_sel_i;
    assign add_cin = link_hi ? carry_q : ctl.cin;

    always_comb begin
        unique case (ctl.a_src)
            A_NEW:   op_a = result_i;
            A_ONES:  op_a = '1;
            default: op_a = old_i;
        endcase
        unique case (ctl.b_src)
            B_NOT_NEW: op_b = ~result_i;
            B_NOT_OLD: op_b = ~old_i;
            default:   op_b = result_i;
        endcase
    end

    dru_adder #(.W(W)) u_add (
        .a_i        (op_a),
        .b_i        (op_b),
        .cin_i      (add_cin),
        .no_carry_i (ctl.no_carry),
        .sum_o      (add_sum),
        .cout_o     (add_cout)
    );

    dru_bitlogic #(.W(W)) u_logic (
        .op_i  (ctl.op),
        .new_i (result_i),
        .old_i (old_i),
        .y_o   (logic_y)
    );

    always_comb begin
        unique case (ctl.op)
            OP_ADDER: merge_val = add_sum;
            OP_AND, OP_OR, OP_ANDN: merge_val = logic_y;
            default:  merge_val = result_i;
        endcase
    end

    assign merged_o = upd_ok ? merge_val : old_i;
    assign we_o     = upd_ok;
    assign carry_o  = upd_ok && (ctl.op == OP_ADDER) && add_cout;

    dru_carry_link u_link (
        .clk       (clk),
        .rst       (rst),
        .capture_i (link_lo && upd_ok),
        .carry_i   (carry_o),
        .carry_q_o (carry_q)
    );

endmodule

// File: rtl/dru_combiner_chk.sv
module dru_combiner_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] result_i,
    input logic [W-1:0] old_i,
    input logic [3:0]   mode_i,
    input logic [1:0]   cat_i,
    input logic         pair_i,
    input logic         hi_sel_i,
    input logic         cmov_i,
    input logic         cond_pass_i,
    input logic [W-1:0] merged_o,
    input logic         we_o,
    input logic         carry_o
);
    logic is_load;
    logic ext_ok;
    logic held;
    logic lo_add;
    logic hi_add;

    assign is_load = (cat_i == 2'd2);
    assign ext_ok  = !(is_load && mode_i[3]);
    assign held    = cmov_i && !cond_pass_i;
    assign lo_add  = !held && is_load && (mode_i == 4'b1011) && pair_i && !hi_sel_i;
    assign hi_add  = !held && is_load && (mode_i == 4'b1011) && pair_i && hi_sel_i;

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        held |-> (!we_o && merged_o == old_i && !carry_o));

    p_write_r12: assert property (@(posedge clk) disable iff (rst)
        !held |-> we_o);

    p_direct_r1: assert property (@(posedge clk) disable iff (rst)
        (!held && mode_i == 4'b0000) |-> (merged_o == result_i && !carry_o));

    p_xor_r2: assert property (@(posedge clk) disable iff (rst)
        (!held && ext_ok && mode_i[2:0] == 3'b001) |-> (merged_o == (result_i ^ old_i)));

    p_inv_r3: assert property (@(posedge clk) disable iff (rst)
        (!held && ext_ok && mode_i[2:0] == 3'b010) |-> (merged_o == ~result_i));

    p_and_r5: assert property (@(posedge clk) disable iff (rst)
        (!held && ext_ok && mode_i[2:0] == 3'b100) |-> (merged_o == (result_i & old_i)));

    p_undef_r11: assert property (@(posedge clk) disable iff (rst)
        (!held && is_load && mode_i[3] && mode_i[2:0] != 3'b011 && mode_i[2:0] != 3'b111)
        |-> (merged_o == result_i && !carry_o));

    p_link_add_r10: assert property (@(posedge clk) disable iff (rst)
        (hi_add && $past(lo_add))
        |-> ({carry_o, merged_o} == ({1'b0, old_i} + {1'b0, result_i} + {{W{1'b0}}, $past(carry_o)})));

endmodule

bind dru_combiner dru_combiner_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .result_i    (result_i),
    .old_i       (old_i),
    .mode_i      (mode_i),
    .cat_i       (cat_i),
    .pair_i      (pair_i),
    .hi_sel_i    (hi_sel_i),
    .cmov_i      (cmov_i),
    .cond_pass_i (cond_pass_i),
    .merged_o    (merged_o),
    .we_o        (we_o),
    .carry_o     (carry_o)
);

// File: tb/dru_combiner_tb_top.sv
module dru_combiner_tb_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] result_i = '0;
    logic [W-1:0] old_i = '0;
    logic [3:0]   mode_i = '0;
    logic [1:0]   cat_i = '0;
    logic         pair_i = 1'b0;
    logic         hi_sel_i = 1'b0;
    logic         cmov_i = 1'b0;
    logic         cond_pass_i = 1'b0;
    logic [W-1:0] merged_o;
    logic         we_o;
    logic         carry_o;

    typedef struct packed {
        logic [W-1:0] val;
        logic         we;
        logic         cy;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    errors = 0;
    logic  st_carry = 1'b0;
    bit    done = 1'b0;

    always #2 clk = ~clk;

    dru_combiner #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .result_i(result_i), .old_i(old_i),
        .mode_i(mode_i), .cat_i(cat_i), .pair_i(pair_i), .hi_sel_i(hi_sel_i),
        .cmov_i(cmov_i), .cond_pass_i(cond_pass_i),
        .merged_o(merged_o), .we_o(we_o), .carry_o(carry_o)
    );

    function automatic exp_t model(input logic [W-1:0] r, input logic [W-1:0] o,
                                   input logic [3:0] m, input logic [1:0] c,
                                   input logic pr, input logic hs,
                                   input logic cm, input logic cp, input logic st);
        exp_t e;
        logic [W:0] s;
        logic linked;
        logic [2:0] m3;
        m3 = m[2:0];
        linked = (c == 2'd2) && m[3] && (m3 == 3'b011 || m3 == 3'b111);
        e.we = 1'b1;
        e.cy = 1'b0;
        e.val = r;
        if (cm && !cp) begin
            e.we = 1'b0;
            e.val = o;
        end else if ((c == 2'd2) && m[3] && !linked) begin
            e.val = r;
        end else begin
            case (m3)
                3'b000: e.val = r;
                3'b001: e.val = r ^ o;
                3'b010: e.val = ~r;
                3'b011: begin
                    s = {1'b0, o} + {1'b0, r} + {{W{1'b0}}, (linked && pr && hs) ? st : 1'b0};
                    e.val = s[W-1:0]; e.cy = s[W];
                end
                3'b100: e.val = r & o;
                3'b101: e.val = r | o;
                3'b110: begin
                    if (c == 2'd1) begin
                        e.val = ~r & o;
                    end else begin
                        s = {1'b0, r} + {1'b0, ~o} + {{W{1'b0}}, 1'b1};
                        e.val = s[W-1:0]; e.cy = s[W];
                    end
                end
                default: begin
                    s = {1'b0, o} + {1'b0, ~r} + {{W{1'b0}}, (linked && pr && hs) ? st : 1'b1};
                    e.val = s[W-1:0]; e.cy = s[W];
                end
            endcase
        end
        return e;
    endfunction

    task automatic drive(input string tag, input logic [W-1:0] r, input logic [W-1:0] o,
                         input logic [3:0] m, input logic [1:0] c,
                         input logic pr, input logic hs,
                         input logic cm, input logic cp);
        exp_t e;
        @(posedge clk);
        #1;
        result_i = r; old_i = o; mode_i = m; cat_i = c;
        pair_i = pr; hi_sel_i = hs; cmov_i = cm; cond_pass_i = cp;
        e = model(r, o, m, c, pr, hs, cm, cp, st_carry);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        if ((c == 2'd2) && m[3] && (m[2:0] == 3'b011 || m[2:0] == 3'b111)
            && pr && !hs && !(cm && !cp)) begin
            st_carry = e.cy;
        end
    endtask

    task automatic op(input string tag, input logic [W-1:0] r, input logic [W-1:0] o,
                      input logic [3:0] m, input logic [1:0] c);
        drive(tag, r, o, m, c, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (merged_o !== e.val || we_o !== e.we || carry_o !== e.cy) begin
                errors++;
                $display("FAIL %s: got val=%h we=%b cy=%b expected val=%h we=%b cy=%b",
                         t, merged_o, we_o, carry_o, e.val, e.we, e.cy);
            end
        end
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        st_carry = 1'b0;
        // R13: captured carry is zero right after reset
        drive("R13 reset link", 32'h5, 32'h7, 4'b1011, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0);
        op("R1 direct", 32'hDEAD_BEEF, 32'h1234_5678, 4'b0000, 2'd0);
        op("R2 xor", 32'hF0F0_1234, 32'h0FF0_FFFF, 4'b0001, 2'd1);
        op("R3 inv a", 32'h0000_00FF, 32'h0, 4'b0010, 2'd0);
        op("R3 inv b", 32'h0000_00FF, 32'hFFFF_FFFF, 4'b0010, 2'd0);
        op("R4 add wrap", 32'h1, 32'hFFFF_FFFF, 4'b0011, 2'd0);
        op("R4 add", 32'h100, 32'h23, 4'b0011, 2'd2);
        op("R5 and", 32'hFF00_FF00, 32'h0F0F_0F0F, 4'b0100, 2'd1);
        op("R5 or", 32'hFF00_0000, 32'h0000_00F0, 4'b0101, 2'd0);
        op("R6 sub borrow", 32'h7, 32'h5, 4'b0111, 2'd0);
        op("R6 sub", 32'h4, 32'h9, 4'b0111, 2'd2);
        op("R7 rsub arith", 32'h9, 32'h4, 4'b0110, 2'd0);
        op("R7 rsub load", 32'h3, 32'h8, 4'b0110, 2'd2);
        op("R7 rsub rsvd", 32'h10, 32'h10, 4'b0110, 2'd3);
        op("R8 andn", 32'h0000_FFFF, 32'h00FF_00FF, 4'b0110, 2'd1);
        op("R9 bit3 arith", 32'hAAAA_0000, 32'h5555_FFFF, 4'b1001, 2'd0);
        op("R9 bit3 bitwise", 32'h0000_FFFF, 32'h00FF_00FF, 4'b1110, 2'd1);
        op("R11 undef load", 32'hCAFE_0001, 32'h1111_1111, 4'b1001, 2'd2);
        op("R11 undef load hi", 32'hCAFE_0002, 32'h2222_2222, 4'b1110, 2'd2);
        // R10: linked add across a pair
        drive("R10 add lo", 32'h1, 32'hFFFF_FFFF, 4'b1011, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
        drive("R10 add hi", 32'h2, 32'h1, 4'b1011, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0);
        // R10: linked subtract with borrow
        drive("R10 sub lo", 32'h1, 32'h0, 4'b1111, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
        drive("R10 sub hi", 32'h1, 32'h5, 4'b1111, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0);
        // R14: unlinked pair ignores captured carry
        drive("R14 link lo", 32'h1, 32'hFFFF_FFFF, 4'b1011, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
        drive("R14 unlinked hi", 32'h2, 32'h1, 4'b0011, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0);
        // R12: conditional move
        drive("R12 cmov fail", 32'h1234, 32'h9999, 4'b0011, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0);
        drive("R12 cmov pass", 32'h1234, 32'h9999, 4'b0001, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1);
        drive("R12 cmov fail direct", 32'hABCD, 32'h5555, 4'b0000, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0);
        wait (exp_q.size() == 0);
        @(posedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule